// File: doc/BRIEF.md
# SPI Master Controller with Register Port

This block is a serial peripheral interface master with a 32-bit register port. A transmit queue and a receive queue sit between that port and the serial engine. Software loads bytes into the transmit data register and releases the engine. The engine then shifts each byte out on the data-out line and captures one byte from the data-in line at the same time. Each captured byte goes into the receive queue, where software reads it back. Clock polarity, clock phase and bit order come from the control register. An internal loopback path serves self-test. The slave-select lines can either be held by software or be pulsed around each byte automatically.

The register port has a valid/ready pair and is always ready. A write takes effect at the clock edge that accepts it. Read data comes back one cycle after the request, flagged by a read-valid strobe. Offsets are byte addresses of 32-bit words. The slave-select register is 0x70. The transmit and receive occupancy registers are 0x74 and 0x78. The control register is 0x60, with status at 0x64. The receive data register is 0x6C and the transmit data register is 0x68. The reset key register is 0x40. Global interrupt enable is 0x1C, interrupt status 0x20 and interrupt enable 0x28.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register reads 0x180 (bit 8 hold and bit 7 manual select set) and status reads 0x5. The select register reads all ones, both occupancies read 0, every ss_n line is high and sclk is low.
- R2: Writing exactly 0x0000000A to offset 0x40 returns every register and both queues to their reset state. Any other value written there changes nothing.
- R3: Each byte is shifted full duplex. With CPOL (control bit 3) and CPHA (control bit 4), sclk idles at CPOL. With CPHA=0, data is sampled on the leading edge; with CPHA=1, on the trailing edge. Bit 9 picks LSB-first order, and MSB-first is the default. Every sclk half period lasts CLK_HALF clock cycles.
- R4: A byte starts only while enable (bit 1) and master (bit 2) are set, hold (bit 8) is clear and the transmit queue is non-empty.
- R5: With loopback (bit 0) set, the receive shifter takes the outgoing data-out bits and ignores miso_i.
- R6: Each byte shifted pushes one byte into the receive queue. The status bits are: bit 0 receive empty, bit 1 receive full, bit 2 transmitter idle (queue empty and engine stopped), bit 3 transmit full. Bit 2 rises only after the last received byte is readable.
- R7: With manual select (bit 7) set, ss_n_o equals the select register at 0x70 (active low, one bit per line). With it clear, the lines cleared in that register go low only while a byte is shifting, and all lines are high otherwise.
- R8: Control bit 5 empties the transmit queue and bit 6 empties the receive queue. Neither bit is stored, so both read back as zero.
- R9: Reading 0x6C with an empty receive queue returns 0 and changes no occupancy. A write to 0x68 while the transmit queue holds FIFO_DEPTH bytes is dropped. Occupancy registers hold byte counts.
- R10: Interrupt status bit 0 is set by every received byte and cleared by writing 1 to it. irq_o is high when global enable (0x1C bit 31), enable (0x28 bit 0) and status bit 0 are all set.
- R11: reg_ready_o is always high. A read accepted at one edge presents its data with reg_rvalid_o high until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register request valid |
| reg_write_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 7 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_ready_o | output | 1 | Request accepted (always 1) |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NUM_SS | Active-low slave selects |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit counter or phase decision in the engine shows up within one byte time. The slave model then captures a different byte, or the receive register returns a bit-shifted value. A queue pointer or count error shows on the occupancy registers at the next read, and as stale or missing bytes when the receive queue drains. A stuck busy or select state shows within a few cycles: the idle status bit never rises and the polling bound expires, or ss_n stays low in automatic mode after the transfer.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    localparam logic [6:0] OFF_GIE   = 7'h1C;
    localparam logic [6:0] OFF_ISR   = 7'h20;
    localparam logic [6:0] OFF_IER   = 7'h28;
    localparam logic [6:0] OFF_KEY   = 7'h40;
    localparam logic [6:0] OFF_CTRL  = 7'h60;
    localparam logic [6:0] OFF_STAT  = 7'h64;
    localparam logic [6:0] OFF_TXD   = 7'h68;
    localparam logic [6:0] OFF_RXD   = 7'h6C;
    localparam logic [6:0] OFF_SSEL  = 7'h70;
    localparam logic [6:0] OFF_TXOCC = 7'h74;
    localparam logic [6:0] OFF_RXOCC = 7'h78;
    localparam logic [31:0] RESET_KEY = 32'h0000_000A;

    // field order follows the control word bit positions, bit 9 first
    typedef struct packed {
        logic lsb_first;
        logic hold;
        logic ss_manual;
        logic clr_rx;
        logic clr_tx;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loopback;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = ctrl_t'(10'h180);
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          clr_i,
    input  logic                          push_i,
    input  logic [WIDTH-1:0]              wdata_i,
    input  logic                          pop_i,
    output logic [WIDTH-1:0]              rdata_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          full_o,
    output logic                          empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_st_t;

    fifo_st_t   st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (st_q.count == CNT_W'(DEPTH));
    assign empty_o = (st_q.count == '0);
    assign count_o = st_q.count;
    assign rdata_o = mem_q[st_q.rptr];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = nxt(st_q.wptr);
            if (do_pop)  st_d.rptr = nxt(st_q.rptr);
            if (do_push && !do_pop) st_d.count = st_q.count + 1'b1;
            if (do_pop && !do_push) st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push && !clr_i) mem_q[st_q.wptr] <= wdata_i;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full_o && !pop_i && !clr_i) |=> $stable(count_o));
    // R8
    clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> empty_o);
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine #(
    parameter int CLK_HALF = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       abort_i,
    input  logic       go_i,
    input  logic       cpol_i,
    input  logic       cpha_i,
    input  logic       lsb_i,
    input  logic       loop_i,
    input  logic       tx_valid_i,
    input  logic [7:0] tx_byte_i,
    input  logic       miso_i,
    output logic       tx_pop_o,
    output logic       rx_push_o,
    output logic [7:0] rx_byte_o,
    output logic       busy_o,
    output logic       sclk_o,
    output logic       mosi_o
);
    localparam int DIV_W  = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam int NEDGE  = 16;
    localparam int EDGE_W = $clog2(NEDGE + 1);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic [DIV_W-1:0]  div;
        logic [EDGE_W-1:0] ecnt;
        logic [7:0]        txs;
        logic [7:0]        rxs;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    din;

    assign mosi_o    = lsb_i ? st_q.txs[0] : st_q.txs[7];
    assign din       = loop_i ? mosi_o : miso_i;
    assign rx_byte_o = st_q.rxs;
    assign busy_o    = st_q.busy;
    assign sclk_o    = st_q.sclk;

    always_comb begin
        st_d      = st_q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        if (abort_i) begin
            st_d.busy = 1'b0;
            st_d.sclk = cpol_i;
            st_d.div  = '0;
            st_d.ecnt = '0;
        end else if (!st_q.busy) begin
            st_d.sclk = cpol_i;
            if (go_i && tx_valid_i) begin
                tx_pop_o  = 1'b1;
                st_d.busy = 1'b1;
                st_d.div  = '0;
                st_d.ecnt = '0;
                st_d.txs  = tx_byte_i;
            end
        end else if (st_q.div == DIV_W'(CLK_HALF - 1)) begin
            st_d.div = '0;
            if (st_q.ecnt == EDGE_W'(NEDGE)) begin
                rx_push_o = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                st_d.sclk = ~st_q.sclk;
                st_d.ecnt = st_q.ecnt + 1'b1;
                // even edges lead, odd edges trail; phase picks the sampling one
                if (st_q.ecnt[0] == cpha_i) begin
                    st_d.rxs = lsb_i ? {din, st_q.rxs[7:1]} : {st_q.rxs[6:0], din};
                end else if (st_q.ecnt != '0 && st_q.ecnt != EDGE_W'(NEDGE - 1)) begin
                    st_d.txs = lsb_i ? (st_q.txs >> 1) : (st_q.txs << 1);
                end
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R4
    pop_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_pop_o && !abort_i) |=> busy_o);
    // R6
    push_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_push_o |=> !busy_o);
    // R3
    sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> (sclk_o == $past(cpol_i)));
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int NUM_SS     = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_HALF   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_valid_i,
    input  logic              reg_write_i,
    input  logic [6:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic              reg_ready_o,
    output logic              reg_rvalid_o,
    output logic [31:0]       reg_rdata_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_SS-1:0] ss_n_o,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        ctrl_t             cfg;
        logic [NUM_SS-1:0] ssr;
        logic              gie;
        logic              ier;
        logic              isr;
        logic              rvalid;
        logic [31:0]       rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic wr, rd, key_hit, clr_tx, clr_rx, tx_push, rx_pop;
    logic tx_pop, rx_push, busy, go;
    logic [7:0] tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;

    assign wr      = reg_valid_i && reg_write_i;
    assign rd      = reg_valid_i && !reg_write_i;
    assign key_hit = wr && (reg_addr_i == OFF_KEY) && (reg_wdata_i == RESET_KEY);
    assign clr_tx  = key_hit || (wr && reg_addr_i == OFF_CTRL && reg_wdata_i[5]);
    assign clr_rx  = key_hit || (wr && reg_addr_i == OFF_CTRL && reg_wdata_i[6]);
    assign tx_push = wr && (reg_addr_i == OFF_TXD);
    assign rx_pop  = rd && (reg_addr_i == OFF_RXD);
    assign go      = st_q.cfg.enable && st_q.cfg.master && !st_q.cfg.hold;

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk_i, .rst_ni, .clr_i(clr_tx), .push_i(tx_push), .wdata_i(reg_wdata_i[7:0]),
        .pop_i(tx_pop), .rdata_o(tx_head), .count_o(tx_cnt), .full_o(tx_full),
        .empty_o(tx_empty));

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk_i, .rst_ni, .clr_i(clr_rx), .push_i(rx_push), .wdata_i(rx_byte),
        .pop_i(rx_pop), .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full),
        .empty_o(rx_empty));

    spim_engine #(.CLK_HALF(CLK_HALF)) i_eng (
        .clk_i, .rst_ni, .abort_i(key_hit), .go_i(go),
        .cpol_i(st_q.cfg.cpol), .cpha_i(st_q.cfg.cpha), .lsb_i(st_q.cfg.lsb_first),
        .loop_i(st_q.cfg.loopback), .tx_valid_i(!tx_empty), .tx_byte_i(tx_head),
        .miso_i, .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_byte_o(rx_byte),
        .busy_o(busy), .sclk_o, .mosi_o);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd;
        if (rd) begin
            unique case (reg_addr_i)
                OFF_CTRL:  st_d.rdata = {22'b0, st_q.cfg};
                OFF_STAT:  st_d.rdata = {28'b0, tx_full, tx_empty && !busy, rx_full, rx_empty};
                OFF_RXD:   st_d.rdata = rx_empty ? 32'b0 : {24'b0, rx_head};
                OFF_SSEL:  st_d.rdata = 32'(st_q.ssr);
                OFF_TXOCC: st_d.rdata = 32'(tx_cnt);
                OFF_RXOCC: st_d.rdata = 32'(rx_cnt);
                OFF_GIE:   st_d.rdata = {st_q.gie, 31'b0};
                OFF_ISR:   st_d.rdata = {31'b0, st_q.isr};
                OFF_IER:   st_d.rdata = {31'b0, st_q.ier};
                default:   st_d.rdata = 32'b0;
            endcase
        end
        if (wr) begin
            unique case (reg_addr_i)
                OFF_CTRL: begin
                    st_d.cfg        = ctrl_t'(reg_wdata_i[9:0]);
                    st_d.cfg.clr_tx = 1'b0;
                    st_d.cfg.clr_rx = 1'b0;
                end
                OFF_SSEL: st_d.ssr = reg_wdata_i[NUM_SS-1:0];
                OFF_GIE:  st_d.gie = reg_wdata_i[31];
                OFF_IER:  st_d.ier = reg_wdata_i[0];
                OFF_ISR:  if (reg_wdata_i[0]) st_d.isr = 1'b0;
                default:  ;
            endcase
        end
        if (rx_push) st_d.isr = 1'b1;
        if (key_hit) begin
            st_d.cfg = CTRL_DEFAULT;
            st_d.ssr = '1;
            st_d.gie = 1'b0;
            st_d.ier = 1'b0;
            st_d.isr = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.cfg <= CTRL_DEFAULT;
            st_q.ssr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_ready_o  = 1'b1;
    assign reg_rvalid_o = st_q.rvalid;
    assign reg_rdata_o  = st_q.rdata;
    assign ss_n_o       = st_q.ssr | {NUM_SS{!(st_q.cfg.ss_manual || busy)}};
    assign irq_o        = st_q.gie && st_q.ier && st_q.isr;

    // R2
    key_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_hit |=> (st_q.cfg == CTRL_DEFAULT && (&st_q.ssr) && tx_empty && rx_empty));
    // R11
    read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd |=> reg_rvalid_o);
    // R7
    auto_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.cfg.ss_manual && rx_push) |=> (&ss_n_o));
endmodule

// File: tb/test_spim_ctrl.sv
`timescale 1ns/1ps
module test_spim_ctrl;
    localparam int NSS = 4, DEPTH = 16, HALF = 2;
    localparam logic [6:0] A_GIE = 7'h1C, A_ISR = 7'h20, A_IER = 7'h28, A_KEY = 7'h40,
        A_CTRL = 7'h60, A_STAT = 7'h64, A_TXD = 7'h68, A_RXD = 7'h6C, A_SSEL = 7'h70,
        A_TXOCC = 7'h74, A_RXOCC = 7'h78;
    localparam int C_LOOP = 1, C_EN = 2, C_MST = 4, C_CPOL = 8, C_CPHA = 16,
        C_CLRTX = 32, C_CLRRX = 64, C_MAN = 128, C_HOLD = 256, C_LSB = 512;

    logic clk = 0, rst_n = 0;
    logic valid = 0, write = 0;
    logic [6:0] addr = 0;
    logic [31:0] wdata = 0;
    logic ready, rvalid, sclk, mosi, irq;
    logic miso;
    logic [31:0] rdata;
    logic [NSS-1:0] ss_n;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    spim_ctrl #(.NUM_SS(NSS), .FIFO_DEPTH(DEPTH), .CLK_HALF(HALF)) i_spim_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(valid), .reg_write_i(write),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_ready_o(ready),
        .reg_rvalid_o(rvalid), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso), .ss_n_o(ss_n), .irq_o(irq));

    // slave model listening on select line 0
    bit s_cpol, s_cpha, s_lsb, prev_sclk, saw_low;
    logic [7:0] s_byte = 0, cap = 0;
    logic [7:0] caps [64];
    int lead = 0, trail = 0, ncap = 0;
    longint t_e1 = 0, t_e2 = 0;

    function automatic logic slave_bit(int j, logic [7:0] b, bit lsb);
        if (j < 0 || j > 7) return 1'b0;
        return b[lsb ? j : 7 - j];
    endfunction

    always @* miso = slave_bit(s_cpha ? lead - 1 : trail, s_byte, s_lsb);

    always @(sclk or ss_n[0]) begin
        if (ss_n[0]) begin
            lead = 0; trail = 0;
        end else if (sclk != prev_sclk) begin
            bit leading;
            leading = (sclk != s_cpol);
            if (leading) lead++; else trail++;
            if (leading != s_cpha) cap = s_lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
            if (ncap == 0 && lead + trail == 1) t_e1 = $time;
            if (ncap == 0 && lead + trail == 2) t_e2 = $time;
            if (lead + trail == 16) begin
                if (ncap < 64) caps[ncap] = cap;
                ncap++; lead = 0; trail = 0;
            end
        end
        prev_sclk = sclk;
    end

    always @(negedge clk) if (!ss_n[0]) saw_low = 1;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
        @(negedge clk); valid = 0; write = 0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d, output logic v);
        @(negedge clk); valid = 1; write = 0; addr = a;
        @(negedge clk); valid = 0; d = rdata; v = rvalid;
    endtask

    function automatic logic [31:0] mode_word(bit lp, bit cpol, bit cpha, bit lsb, bit man);
        return C_EN | C_MST | (lp ? C_LOOP : 0) | (cpol ? C_CPOL : 0) | (cpha ? C_CPHA : 0)
             | (lsb ? C_LSB : 0) | (man ? C_MAN : 0);
    endfunction

    task automatic wait_idle(string req);
        logic [31:0] d; logic v; int guard = 0;
        do begin rd(A_STAT, d, v); guard++; end while (!d[2] && guard < 400);
        chk(d[2] == 1'b1, req, d, 32'h4);
    endtask

    task automatic burst(bit lp, bit cpol, bit cpha, bit lsb, bit man, int n,
                         logic [7:0] sb, bit check_half);
        logic [31:0] base, d; logic v;
        logic [7:0] tx [4];
        s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_byte = sb; ncap = 0; saw_low = 0;
        base = mode_word(lp, cpol, cpha, lsb, man);
        wr(A_SSEL, 32'hF);
        wr(A_CTRL, base | C_HOLD);
        wr(A_SSEL, 32'hE);
        for (int i = 0; i < n; i++) begin
            tx[i] = 8'($urandom);
            wr(A_TXD, {24'b0, tx[i]});
        end
        // R7: manual follows the register, automatic stays high while idle
        chk(ss_n == (man ? 4'hE : 4'hF), "R7 select before start", {28'b0, ss_n}, man ? 32'hE : 32'hF);
        wr(A_CTRL, base);
        wait_idle("R6 idle after burst");
        chk(saw_low, "R7 select low while shifting", {31'b0, saw_low}, 1);
        if (!man) chk(ss_n == 4'hF, "R7 auto select released", {28'b0, ss_n}, 32'hF);
        rd(A_RXOCC, d, v);
        chk(d == 32'(n), "R6 one received byte per sent byte", d, 32'(n));
        for (int i = 0; i < n; i++) begin
            rd(A_RXD, d, v);
            chk(d == {24'b0, lp ? tx[i] : sb}, lp ? "R5 loopback byte" : "R3 received byte",
                d, {24'b0, lp ? tx[i] : sb});
            chk(caps[i] == tx[i], "R3 slave captured byte", {24'b0, caps[i]}, {24'b0, tx[i]});
        end
        if (check_half)
            chk(t_e2 - t_e1 == longint'(HALF * 10), "R3 sclk half period",
                32'(t_e2 - t_e1), 32'(HALF * 10));
        wr(A_CTRL, base | C_HOLD);
        wr(A_SSEL, 32'hF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d; logic v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(ss_n == 4'hF && sclk == 0, "R1 pins after reset", {27'b0, sclk, ss_n}, 32'hF);
        chk(ready == 1'b1, "R11 ready", {31'b0, ready}, 1);
        rd(A_CTRL, d, v); chk(d == 32'h180, "R1 control default", d, 32'h180);
        chk(v == 1'b1, "R11 read valid", {31'b0, v}, 1);
        rd(A_STAT, d, v); chk(d == 32'h5, "R1 status default", d, 32'h5);
        rd(A_SSEL, d, v); chk(d == 32'hF, "R1 select default", d, 32'hF);
        rd(A_TXOCC, d, v); chk(d == 0, "R1 tx occupancy", d, 0);

        // R9 empty read
        rd(A_RXD, d, v); chk(d == 0, "R9 empty read returns zero", d, 0);
        rd(A_RXOCC, d, v); chk(d == 0, "R9 empty read keeps count", d, 0);

        // R9 full drop, R8 transmit clear
        for (int i = 0; i < DEPTH + 1; i++) wr(A_TXD, 32'(i));
        rd(A_TXOCC, d, v); chk(d == DEPTH, "R9 full write dropped", d, DEPTH);
        rd(A_STAT, d, v); chk(d[3] == 1'b1, "R6 transmit full flag", d, 32'h9);
        wr(A_CTRL, C_HOLD | C_MAN | C_CLRTX);
        rd(A_TXOCC, d, v); chk(d == 0, "R8 transmit queue cleared", d, 0);
        rd(A_CTRL, d, v); chk(d == 32'h180, "R8 clear bits read zero", d, 32'h180);

        // R4 start gating
        wr(A_TXD, 32'h5A);
        wr(A_CTRL, C_MST | C_MAN);
        repeat (60) @(negedge clk);
        rd(A_TXOCC, d, v); chk(d == 1, "R4 no start without enable", d, 1);
        wr(A_CTRL, C_EN | C_MAN);
        repeat (60) @(negedge clk);
        rd(A_TXOCC, d, v); chk(d == 1, "R4 no start without master", d, 1);
        wr(A_CTRL, C_EN | C_MST | C_MAN | C_HOLD);
        repeat (60) @(negedge clk);
        rd(A_TXOCC, d, v); chk(d == 1, "R4 no start while held", d, 1);
        chk(sclk == 0, "R3 sclk idle at polarity", {31'b0, sclk}, 0);
        wr(A_CTRL, C_EN | C_MST | C_MAN | C_LOOP);
        wait_idle("R4 starts when allowed");
        rd(A_RXD, d, v); chk(d == 32'h5A, "R5 loopback gated byte", d, 32'h5A);

        // R3 directed: every mode in both bit orders
        for (int m = 0; m < 8; m++)
            burst(0, m[0], m[1], m[2], 1, 2, 8'hC3 ^ 8'(m * 17), m == 0);

        // R5 loopback with miso driven by the slave
        burst(1, 1, 0, 0, 0, 3, 8'hFF, 0);

        // R10 interrupt
        wr(A_ISR, 1);
        rd(A_ISR, d, v); chk(d == 0, "R10 status cleared by one", d, 0);
        burst(0, 0, 1, 0, 0, 1, 8'h96, 0);
        rd(A_ISR, d, v); chk(d == 1, "R10 status set by byte", d, 1);
        chk(irq == 0, "R10 irq masked", {31'b0, irq}, 0);
        wr(A_IER, 1);
        chk(irq == 0, "R10 irq needs global enable", {31'b0, irq}, 0);
        wr(A_GIE, 32'h8000_0000);
        chk(irq == 1, "R10 irq raised", {31'b0, irq}, 1);
        wr(A_ISR, 1);
        chk(irq == 0, "R10 irq dropped after clear", {31'b0, irq}, 0);

        // R8 receive clear
        wr(A_CTRL, C_EN | C_MST | C_LOOP);
        wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        wait_idle("R6 idle before receive clear");
        wr(A_CTRL, C_EN | C_MST | C_LOOP | C_HOLD | C_CLRRX);
        rd(A_RXOCC, d, v); chk(d == 0, "R8 receive queue cleared", d, 0);

        // R2 reset key
        wr(A_CTRL, 32'h1F); wr(A_SSEL, 32'h3); wr(A_TXD, 32'h77);
        wr(A_KEY, 32'h0B);
        rd(A_CTRL, d, v); chk(d == 32'h1F, "R2 wrong key ignored", d, 32'h1F);
        wr(A_KEY, 32'h10A);
        rd(A_SSEL, d, v); chk(d == 32'h3, "R2 wide wrong key ignored", d, 32'h3);
        wr(A_KEY, 32'h0A);
        rd(A_CTRL, d, v); chk(d == 32'h180, "R2 control reset", d, 32'h180);
        rd(A_SSEL, d, v); chk(d == 32'hF, "R2 select reset", d, 32'hF);
        rd(A_STAT, d, v); chk(d == 32'h5, "R2 queues reset", d, 32'h5);

        // constrained random bursts
        for (int k = 0; k < 20; k++) begin
            bit lp;
            lp = ($urandom % 4) == 0;
            burst(lp, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  1 + ($urandom % 3), 8'($urandom), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule